// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns one request for a NAND bus access into the strobe and bus-drive waveform for that access. A request is one of three kinds: a command cycle, an address cycle or a data cycle. Data cycles may be reads or writes. Command and address cycles are always writes of one byte. Each access passes through a fixed order of phases. An optional ready phase waits on the device busy line. An optional turnaround gap comes next. Then the access runs through setup, strobe and hold. Chip enable stays low from the first phase to the last.

Two timing banks hold the phase lengths. The data bank times data cycles. The control bank times command and address cycles. A small control register holds five things: the bank enable, the ready-wait enable, the bus width, and the two gaps a read must leave after a command cycle or after an address cycle. The controller writes these through a simple write port. The timing of an access is captured when the request is accepted, so a write to the configuration during an access has no effect on that access.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset the chip enable and both strobes are high, the data bus is not driven, busy and rd_valid are low and req_ready is low. The control register resets to 0x7F8: gaps of 15, 8-bit width, ready-wait off, bank off. Both timing banks reset to 0x0A0A0A0A.
- R2: While the bank enable (control bit 0) is low, req_ready is low, a request starts no access and the chip enable stays high.
- R3: An accepted access drives the chip enable low from the cycle after acceptance. It then runs setup for S cycles with both strobes high, then the strobe low for exactly W cycles, then hold for H cycles with both strobes high. The chip enable returns high in the cycle after the last hold cycle.
- R4: Command cycles (req_kind 0) raise CLE and address cycles (req_kind 1) raise ALE for the whole access. Both are timed by the control bank at config address 2. Data cycles (req_kind 2 or 3) use the data bank at config address 1. Each bank word holds setup in [7:0], strobe in [15:8], hold in [23:16] and high-Z in [31:24].
- R5: A programmed setup, strobe or hold count of zero acts as one cycle.
- R6: A write leaves the data bus undriven for the first hiz+1 strobe cycles and drives it for the rest of the strobe phase and through hold. A read never drives the bus.
- R7: Control bit 2 selects a 16-bit bus for data cycles. In 8-bit mode, and always for command and address cycles, only the low byte is driven or captured and the upper byte is zero.
- R8: A read samples the bus at the end of its last strobe cycle. rd_data then holds that value, and rd_valid is high for exactly the first hold cycle.
- R9: A data read that directly follows a command cycle inserts a gap of G+1 cycles before its setup, where G is control bits [6:3]. If it follows an address cycle, G is control bits [10:7]. During the gap the chip enable is low and the strobes are high. A read after a data cycle, and any write, has no gap.
- R10: With ready-wait (control bit 1) set, a request accepted while nand_rb is low holds the chip enable low with both strobes high until nand_rb is seen high. With ready-wait clear, nand_rb has no effect.
- R11: busy is high from the cycle after acceptance to the last hold cycle. req_ready is low throughout, so a new request is accepted only after the hold phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 control, 1 data bank, 2 command/address bank, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 command, 1 address, 2/3 data |
| req_write | input | 1 | Data cycle direction (1 write) |
| req_wdata | input | 16 | Write byte or word |
| req_ready | output | 1 | Request accepted this cycle when valid |
| busy | output | 1 | Access in progress |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | rd_data updated |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus input value |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench targets the read turnaround gap after a command cycle, after an address cycle and after a data cycle. A design that lost track of the previous kind would drop the gap or stretch reads that need none. Zero counts and the first high-Z cycles of a write are checked cycle by cycle. An off-by-one there shows up as a strobe one cycle short or long, or as the bus driven one cycle early. Width handling is checked for command bytes sent while the bus is 16 bits wide. The ready line is driven low with ready-wait on and with it off. This exposes a design that ignores the busy device or one that stalls when it should not.

// File: rtl/nand_tg_pkg.sv
package nand_tg_pkg;

    localparam int CNT_W  = 8;
    localparam int GAP_W  = 4;
    localparam int DQ_W   = 16;
    localparam int HALF_W = DQ_W / 2;
    localparam int CFG_W  = 32;
    localparam int CTRL_W = 3 + 2 * GAP_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_DATA = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RDY,
        PH_GAP,
        PH_SETUP,
        PH_STRB,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        cnt_t hiz;
        cnt_t hold;
        cnt_t strb;
        cnt_t setup;
    } bank_t;

    typedef struct packed {
        logic [GAP_W-1:0] ale_gap;
        logic [GAP_W-1:0] cle_gap;
        logic             wide;
        logic             rb_wait;
        logic             enable;
    } ctrl_t;

    typedef struct packed {
        kind_e            kind;
        logic             write;
        logic             wide;
        logic [DQ_W-1:0]  wdata;
        cnt_t             setup_len;
        cnt_t             strb_len;
        cnt_t             hold_len;
        cnt_t             hiz;
        logic [GAP_W:0]   gap_len;
        logic             need_gap;
    } job_t;

    localparam bank_t BANK_RST = '{default: cnt_t'(10)};
    localparam ctrl_t CTRL_RST = '{ale_gap: '1, cle_gap: '1, wide: 1'b0,
                                   rb_wait: 1'b0, enable: 1'b0};

    function automatic cnt_t at_least_one(input cnt_t v);
        return (v == '0) ? cnt_t'(1) : v;
    endfunction

    function automatic kind_e decode_kind(input logic [1:0] code);
        case (code)
            2'd0:    return KIND_CMD;
            2'd1:    return KIND_ADDR;
            default: return KIND_DATA;
        endcase
    endfunction

endpackage

// File: rtl/nand_tg_regs.sv
module nand_tg_regs
    import nand_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output ctrl_t            ctrl,
    output bank_t            data_bank,
    output bank_t            ctl_bank
);

    localparam int NBANK = 2;

    bank_t bank_q [NBANK];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RST;
        end else if (cfg_wr && cfg_addr == 2'd0) begin
            ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= BANK_RST;
            end else if (cfg_wr && cfg_addr == 2'(g + 1)) begin
                bank_q[g] <= bank_t'(cfg_wdata[4*CNT_W-1:0]);
            end
        end
    end

    assign data_bank = bank_q[0];
    assign ctl_bank  = bank_q[1];

endmodule

// File: rtl/nand_tg_seq.sv
module nand_tg_seq
    import nand_tg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            start_hold,
    input  job_t            job,
    input  logic            rb,
    output phase_e          phase,
    output cnt_t            cnt,
    output kind_e           last_kind,
    output kind_e           cur_kind,
    output logic            cur_write,
    output logic            cur_wide,
    output logic [DQ_W-1:0] cur_wdata,
    output cnt_t            cur_strb_len,
    output cnt_t            cur_hiz
);

    job_t job_q;

    function automatic phase_e after_ready(input logic gap);
        return gap ? PH_GAP : PH_SETUP;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            job_q     <= '0;
            last_kind <= KIND_DATA;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        job_q <= job;
                        phase <= start_hold ? PH_RDY : after_ready(job.need_gap);
                    end
                end
                PH_RDY: begin
                    cnt <= '0;
                    if (rb) begin
                        phase <= after_ready(job_q.need_gap);
                    end
                end
                PH_GAP: begin
                    if (cnt == cnt_t'(job_q.gap_len - 1'b1)) begin
                        cnt   <= '0;
                        phase <= PH_SETUP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (cnt == job_q.setup_len - 1'b1) begin
                        cnt   <= '0;
                        phase <= PH_STRB;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STRB: begin
                    if (cnt == job_q.strb_len - 1'b1) begin
                        cnt   <= '0;
                        phase <= PH_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == job_q.hold_len - 1'b1) begin
                        cnt       <= '0;
                        phase     <= PH_IDLE;
                        last_kind <= job_q.kind;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt   <= '0;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    assign cur_kind     = job_q.kind;
    assign cur_write    = job_q.write;
    assign cur_wide     = job_q.wide;
    assign cur_wdata    = job_q.wdata;
    assign cur_strb_len = job_q.strb_len;
    assign cur_hiz      = job_q.hiz;

endmodule

// File: rtl/nand_tg_pins.sv
module nand_tg_pins
    import nand_tg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  phase_e          phase,
    input  cnt_t            cnt,
    input  kind_e           kind,
    input  logic            write,
    input  logic            wide,
    input  logic [DQ_W-1:0] wdata,
    input  cnt_t            strb_len,
    input  cnt_t            hiz,
    input  logic [DQ_W-1:0] dq_in,
    output logic            ce_n,
    output logic            cle,
    output logic            ale,
    output logic            we_n,
    output logic            re_n,
    output logic            dq_oe,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] rd_data,
    output logic            rd_valid
);

    logic active, in_strb, past_hiz, last_strb;

    always_comb begin
        active    = (phase != PH_IDLE);
        in_strb   = (phase == PH_STRB);
        past_hiz  = ({1'b0, cnt} > {1'b0, hiz});
        last_strb = in_strb && (cnt == strb_len - 1'b1);
        ce_n      = !active;
        cle       = active && (kind == KIND_CMD);
        ale       = active && (kind == KIND_ADDR);
        we_n      = !(in_strb && write);
        re_n      = !(in_strb && !write);
        dq_oe     = write && ((in_strb && past_hiz) || (phase == PH_HOLD));
        dq_out    = dq_oe ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= last_strb && !write;
            if (last_strb && !write) begin
                rd_data <= wide ? dq_in : {{HALF_W{1'b0}}, dq_in[HALF_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
    import nand_tg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic        req_write,
    input  logic [15:0] req_wdata,
    output logic        req_ready,
    output logic        busy,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [15:0] nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [15:0] nand_dq_in,
    input  logic        nand_rb
);

    ctrl_t  ctrl_q;
    bank_t  data_bank, ctl_bank, sel_bank;
    job_t   job;
    phase_e phase;
    cnt_t   cnt;
    kind_e  last_kind, cur_kind, kind;
    logic   cur_write, cur_wide, is_data, start, start_hold, bank_en;
    logic [DQ_W-1:0] cur_wdata;
    cnt_t   cur_strb_len, cur_hiz;
    logic [GAP_W-1:0] gap_sel;

    nand_tg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl_q),
        .data_bank (data_bank),
        .ctl_bank  (ctl_bank)
    );

    assign bank_en   = ctrl_q.enable;
    assign busy      = (phase != PH_IDLE);
    assign req_ready = !busy && bank_en;
    assign start     = req_valid && req_ready;
    assign start_hold = ctrl_q.rb_wait && !nand_rb;

    always_comb begin
        kind     = decode_kind(req_kind);
        is_data  = (kind == KIND_DATA);
        sel_bank = is_data ? data_bank : ctl_bank;
        gap_sel  = (last_kind == KIND_CMD) ? ctrl_q.cle_gap : ctrl_q.ale_gap;

        job.kind      = kind;
        job.write     = !is_data || req_write;
        job.wide      = is_data && ctrl_q.wide;
        job.wdata     = job.wide ? req_wdata
                                 : {{HALF_W{1'b0}}, req_wdata[HALF_W-1:0]};
        job.setup_len = at_least_one(sel_bank.setup);
        job.strb_len  = at_least_one(sel_bank.strb);
        job.hold_len  = at_least_one(sel_bank.hold);
        job.hiz       = sel_bank.hiz;
        job.gap_len   = {1'b0, gap_sel} + 1'b1;
        job.need_gap  = is_data && !req_write && (last_kind != KIND_DATA);
    end

    nand_tg_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_hold   (start_hold),
        .job          (job),
        .rb           (nand_rb),
        .phase        (phase),
        .cnt          (cnt),
        .last_kind    (last_kind),
        .cur_kind     (cur_kind),
        .cur_write    (cur_write),
        .cur_wide     (cur_wide),
        .cur_wdata    (cur_wdata),
        .cur_strb_len (cur_strb_len),
        .cur_hiz      (cur_hiz)
    );

    nand_tg_pins u_pins (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .cnt      (cnt),
        .kind     (cur_kind),
        .write    (cur_write),
        .wide     (cur_wide),
        .wdata    (cur_wdata),
        .strb_len (cur_strb_len),
        .hiz      (cur_hiz),
        .dq_in    (nand_dq_in),
        .ce_n     (nand_ce_n),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .dq_oe    (nand_dq_oe),
        .dq_out   (nand_dq_out),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/nand_cycle_gen_chk.sv
module nand_cycle_gen_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic busy,
    input logic bank_en,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe,
    input logic rd_valid
);

    p_idle_ce_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> nand_ce_n);

    p_off_no_ready_r2: assert property (@(posedge clk) disable iff (rst)
        !bank_en |-> !req_ready);

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    p_strobe_under_ce_r3: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    p_latch_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (rst)
        nand_dq_oe |-> nand_re_n);

    p_capture_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (nand_re_n && !$past(nand_re_n)));

    p_accept_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    p_busy_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

endmodule

bind nand_cycle_gen nand_cycle_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .busy       (busy),
    .bank_en    (bank_en),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .rd_valid   (rd_valid)
);

// File: tb/nand_cycle_gen_test.sv
module nand_cycle_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, busy, rd_valid;
    logic [15:0] rd_data;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = '0;
    logic        nand_rb = 1'b1;

    always #4 clk = ~clk;

    nand_cycle_gen uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .req_wdata(req_wdata), .req_ready(req_ready),
        .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model of programmed state
    logic [31:0] m_data_bank = 32'h0A0A0A0A;
    logic [31:0] m_ctl_bank  = 32'h0A0A0A0A;
    bit          m_en = 0, m_rbw = 0, m_wide = 0;
    int          m_cle_gap = 15, m_ale_gap = 15;
    int          m_last = 2;

    // expected vector: {ce_n, cle, ale, we_n, re_n, oe, busy, rd_valid, ready}
    logic [8:0]  exp_q [$];
    logic [15:0] exp_dq, exp_rd;
    string       cur_tag = "R3";
    int          pidx = 0;
    int          rb_release = 0;

    task automatic report(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the queued reference
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                logic [8:0] e;
                logic [8:0] a;
                e = exp_q.pop_front();
                pidx++;
                a = {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n,
                     nand_dq_oe, busy, rd_valid, req_ready};
                report(cur_tag, $sformatf("pins cycle %0d", pidx), 32'(a), 32'(e));
                if (e[3]) report(cur_tag, "dq_out", 32'(nand_dq_out), 32'(exp_dq));
                if (e[1]) report(cur_tag, "rd_data", 32'(rd_data), 32'(exp_rd));
                if (rb_release > 0 && pidx == rb_release) nand_rb = 1'b1;
            end
        end
    end

    task automatic cfg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_wr = 1'b0;
        case (a)
            2'd0: begin
                m_en = d[0]; m_rbw = d[1]; m_wide = d[2];
                m_cle_gap = int'(d[6:3]); m_ale_gap = int'(d[10:7]);
            end
            2'd1: m_data_bank = d;
            2'd2: m_ctl_bank  = d;
            default: ;
        endcase
    endtask

    function automatic int min1(input logic [7:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    function automatic logic [8:0] vec(input bit ce_n, cle, ale, we_n, re_n,
                                       oe, bsy, rdv, rdy);
        return {ce_n, cle, ale, we_n, re_n, oe, bsy, rdv, rdy};
    endfunction

    // kind: 0 cmd, 1 addr, 2 data
    task automatic access(input int kind, input bit wr, input logic [15:0] wd,
                          input logic [15:0] din, input int rb_low,
                          input string tag);
        logic [31:0] b;
        int s, w, h, hz, gap, nrdy;
        bit isw, wide_e, c, l;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        b      = (kind == 2) ? m_data_bank : m_ctl_bank;
        s      = min1(b[7:0]);
        w      = min1(b[15:8]);
        h      = min1(b[23:16]);
        hz     = int'(b[31:24]);
        isw    = (kind != 2) || wr;
        wide_e = (kind == 2) && m_wide;
        c      = (kind == 0);
        l      = (kind == 1);
        gap    = 0;
        if (kind == 2 && !wr && m_last == 0) gap = m_cle_gap + 1;
        if (kind == 2 && !wr && m_last == 1) gap = m_ale_gap + 1;
        nrdy   = (m_rbw && rb_low > 0) ? rb_low : 0;
        exp_dq = wide_e ? wd : {8'h00, wd[7:0]};
        exp_rd = wide_e ? din : {8'h00, din[7:0]};
        nand_dq_in = din;
        nand_rb    = (rb_low > 0) ? 1'b0 : 1'b1;
        rb_release = rb_low;
        pidx       = 0;
        cur_tag    = tag;
        report(tag, "ready before request (R11)", 32'(req_ready), 32'(1));
        for (int i = 0; i < nrdy; i++) exp_q.push_back(vec(0, c, l, 1, 1, 0, 1, 0, 0));
        for (int i = 0; i < gap; i++)  exp_q.push_back(vec(0, c, l, 1, 1, 0, 1, 0, 0));
        for (int i = 0; i < s; i++)    exp_q.push_back(vec(0, c, l, 1, 1, 0, 1, 0, 0));
        for (int i = 0; i < w; i++)
            exp_q.push_back(vec(0, c, l, !isw, isw, isw && (i >= hz + 1), 1, 0, 0));
        for (int i = 0; i < h; i++)
            exp_q.push_back(vec(0, c, l, 1, 1, isw, 1, (i == 0) && !isw, 0));
        exp_q.push_back(vec(1, 0, 0, 1, 1, 0, 0, 0, 1));
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_write = wr;
        req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        m_last = kind;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #3;
        // R1 reset state
        report("R1", "ce_n", 32'(nand_ce_n), 32'(1));
        report("R1", "strobes", 32'({nand_we_n, nand_re_n}), 32'(2'b11));
        report("R1", "dq_oe", 32'(nand_dq_oe), 32'(0));
        report("R1", "busy/rd_valid", 32'({busy, rd_valid}), 32'(0));
        report("R1", "ready with bank off", 32'(req_ready), 32'(0));

        // R2: disabled bank ignores requests
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #3;
            report("R2", "ce_n stays high", 32'(nand_ce_n), 32'(1));
            report("R2", "busy stays low", 32'(busy), 32'(0));
        end
        @(negedge clk);
        req_valid = 1'b0;

        // enable bank, reset gaps kept at 15; default banks (R1 defaults)
        cfg(2'd0, 32'h0000_07F9);
        access(0, 1, 16'h00FF, 16'h0000, 0, "R1 R3 R4");
        access(2, 0, 16'h0000, 16'h0033, 0, "R1 R8 R9");

        // program distinct banks and gaps
        cfg(2'd1, 32'h0001_0302);
        cfg(2'd2, 32'h0002_0201);
        cfg(2'd0, 32'h0000_0299);
        access(0, 1, 16'h0070, 16'h0000, 0, "R3 R4");
        access(2, 0, 16'h0000, 16'h005A, 0, "R8 R9");
        access(1, 1, 16'h0012, 16'h0000, 0, "R4");
        access(2, 0, 16'h0000, 16'h00A5, 0, "R9");
        access(2, 0, 16'h0000, 16'h003C, 0, "R9");
        access(2, 1, 16'h1234, 16'h0000, 0, "R6 R7");

        // R5 zero counts
        cfg(2'd1, 32'h0000_0000);
        access(2, 1, 16'h00C7, 16'h0000, 0, "R5");
        access(2, 0, 16'h0000, 16'h0081, 0, "R5 R8");

        // R7 wide bus
        cfg(2'd1, 32'h0001_0302);
        cfg(2'd0, 32'h0000_029D);
        access(2, 1, 16'hBEEF, 16'h0000, 0, "R7");
        access(0, 1, 16'hFFAB, 16'h0000, 0, "R7");
        access(2, 0, 16'h0000, 16'hC3A5, 0, "R7 R8 R9");
        cfg(2'd0, 32'h0000_0299);
        access(2, 0, 16'h0000, 16'hC3A5, 0, "R7");

        // R6 high-Z lead
        cfg(2'd1, 32'h0202_0601);
        access(2, 1, 16'h005E, 16'h0000, 0, "R6");

        // R10 ready wait
        cfg(2'd0, 32'h0000_029B);
        access(2, 1, 16'h0011, 16'h0000, 3, "R10");
        access(0, 1, 16'h0022, 16'h0000, 2, "R10");
        cfg(2'd0, 32'h0000_0299);
        access(2, 1, 16'h0033, 16'h0000, 3, "R10");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule